// File: doc/BRIEF.md
# Byte/Word Integer ALU with Status Flags

This block is the integer execute stage of a small processor core. Each accepted operation takes two operands and a selector for 8-bit or 16-bit width. Add, subtract, compare, the three bitwise operations, bitwise inversion and negation are all handled here. The caller also supplies the current status vector, which provides the carry or borrow input and the previous zero flag.

One clock edge later, the block presents three outputs. The first is the result, masked to the selected width. The second is a one-cycle write strobe for the destination register. The third is a registered five-bit status vector. Besides zero, overflow, carry and negative, the vector carries a marker bit that is set when a table-terminator value is seen: the most negative number of the selected width.

The compare and extended operations let software build loops and multi-precision arithmetic. The zero flag of an extended add or subtract stays set only if it was already set, so a chain of word operations yields one zero test for the whole wide value.

Top module: `status_alu`

## Requirements
- R1: The status vector has the marker flag at bit 4, zero at bit 3, overflow at bit 2, carry at bit 1 and negative at bit 0. Opcode 0 adds and opcode 1 adds plus the incoming carry bit (flags_in bit 1). Both set carry on a carry out of the selected width's top bit.
- R2: Opcode 2 subtracts b from a and opcode 3 also subtracts the incoming carry bit as a borrow. Opcode 9 computes 0 minus a. For all three, carry is set when a borrow is generated.
- R3: For add, subtract, compare and negate, overflow is set exactly when the true signed result lies outside the range of the selected width.
- R4: Zero is set when the masked result is zero. For opcodes 1 and 3 it is set only when, in addition, flags_in bit 3 was set.
- R5: The marker flag is set when the operand under test equals 0x80 in byte mode or 0x8000 in word mode. The operand under test is a for opcodes 8 and 9, and b for every other defined opcode.
- R6: The negative flag equals bit 7 (byte mode) or bit 15 (word mode) of the result.
- R7: Opcodes 5, 6 and 7 give a AND b, a OR b and a XOR b. Opcode 8 gives the bitwise inverse of a. For these four opcodes, overflow and carry are cleared.
- R8: Opcode 4 updates the flags as a subtraction would. It never raises the write strobe and leaves result_out unchanged.
- R9: With word_mode low, only bits 7:0 of the operands take part, and the upper byte of result_out is zero.
- R10: Results and flags appear one cycle after valid_in. While valid_in is low, flags_out and result_out hold their values and wr_en_out is low.
- R11: A synchronous reset clears flags_out, result_out and wr_en_out.
- R12: Opcodes 10 to 15 leave the flags and the result unchanged and do not raise the write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operation accepted this cycle |
| word_mode | input | 1 | 1 = 16-bit, 0 = 8-bit |
| op_code | input | 4 | Operation select |
| opnd_a | input | 16 | First operand (destination value) |
| opnd_b | input | 16 | Second operand |
| flags_in | input | 5 | Current status vector |
| result_out | output | 16 | Registered result |
| wr_en_out | output | 1 | One-cycle destination write strobe |
| flags_out | output | 5 | Registered status vector |

## Verification
Two flag functions can fall in the same cycle. The first is the chained zero test of an extended subtract; the second is borrow generation from the incoming carry. Both are provoked by a subtract-with-borrow whose operands differ by exactly one, with the incoming carry and zero bits both set, and by the same case with the zero bit cleared. The result is judged on flags_out: zero must follow the incoming zero bit while carry stays clear.

A second collision occurs when negating the most negative value. That single operation must raise the marker, overflow, carry and negative flags together.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_NEG  = 4'd9
  } alu_op_e;

  localparam int NFLAG = 5;
  localparam int FL_E  = 4;
  localparam int FL_Z  = 3;
  localparam int FL_V  = 2;
  localparam int FL_C  = 1;
  localparam int FL_N  = 0;

endpackage

// File: rtl/sa_arith.sv
module sa_arith #(
  parameter int W = 16
) (
  input  logic         word_mode,
  input  logic         is_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cflag,
  output logic         ovf
);
  localparam int HW = W / 2;

  logic [W-1:0] mask;
  logic [W-1:0] am;
  logic [W-1:0] bm;
  logic         ci;
  logic [W:0]   full;
  logic         raw_carry;
  logic         sa, sb, sr;

  always_comb begin
    mask      = word_mode ? {W{1'b1}} : {{(W-HW){1'b0}}, {HW{1'b1}}};
    am        = a & mask;
    bm        = (is_sub ? ~b : b) & mask;
    ci        = is_sub ? ~cin : cin;
    full      = {1'b0, am} + {1'b0, bm} + {{W{1'b0}}, ci};
    raw_carry = word_mode ? full[W] : full[HW];
    cflag     = is_sub ? ~raw_carry : raw_carry;
    sum       = full[W-1:0] & mask;
    sa        = word_mode ? am[W-1]  : am[HW-1];
    sb        = word_mode ? bm[W-1]  : bm[HW-1];
    sr        = word_mode ? sum[W-1] : sum[HW-1];
    ovf       = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/sa_logic.sv
module sa_logic #(
  parameter int W = 16
) (
  input  status_alu_pkg::alu_op_e op,
  input  logic [W-1:0]            a,
  input  logic [W-1:0]            b,
  input  logic [W-1:0]            mask,
  output logic [W-1:0]            y
);
  import status_alu_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b & mask;
      OP_OR:   y = (a | b) & mask;
      OP_XOR:  y = (a ^ b) & mask;
      OP_CPL:  y = ~a & mask;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/status_alu.sv
module status_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic         word_mode,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [4:0]   flags_in,
  output logic [W-1:0] result_out,
  output logic         wr_en_out,
  output logic [4:0]   flags_out
);
  import status_alu_pkg::*;

  localparam int HW = W / 2;

  alu_op_e      op;
  logic [W-1:0] mask;
  logic [W-1:0] min_val;
  logic         is_arith, is_sub, is_logic, known, writes;
  logic [W-1:0] ar_a, ar_b, ar_sum, lg_y, res, e_src;
  logic         ar_cin, ar_c, ar_v;
  logic [4:0]   nf;

  assign op = alu_op_e'(op_code);

  always_comb begin
    mask    = word_mode ? {W{1'b1}} : {{(W-HW){1'b0}}, {HW{1'b1}}};
    min_val = word_mode ? {1'b1, {(W-1){1'b0}}}
                        : {{(W-HW){1'b0}}, 1'b1, {(HW-1){1'b0}}};
    is_sub   = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP) || (op == OP_NEG);
    is_arith = is_sub || (op == OP_ADD) || (op == OP_ADDC);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_CPL);
    known    = is_arith || is_logic;
    writes   = known && (op != OP_CMP);
    ar_a     = (op == OP_NEG) ? '0 : opnd_a;
    ar_b     = (op == OP_NEG) ? opnd_a : opnd_b;
    ar_cin   = ((op == OP_ADDC) || (op == OP_SUBC)) ? flags_in[FL_C] : 1'b0;
  end

  sa_arith #(.W(W)) u_arith (
    .word_mode (word_mode),
    .is_sub    (is_sub),
    .a         (ar_a),
    .b         (ar_b),
    .cin       (ar_cin),
    .sum       (ar_sum),
    .cflag     (ar_c),
    .ovf       (ar_v)
  );

  sa_logic #(.W(W)) u_logic (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .mask (mask),
    .y    (lg_y)
  );

  always_comb begin
    res   = is_arith ? ar_sum : lg_y;
    e_src = ((op == OP_CPL) || (op == OP_NEG)) ? opnd_a : opnd_b;
    nf[FL_E] = (e_src & mask) == min_val;
    nf[FL_Z] = (res == '0) &&
               (((op == OP_ADDC) || (op == OP_SUBC)) ? flags_in[FL_Z] : 1'b1);
    nf[FL_V] = is_arith ? ar_v : 1'b0;
    nf[FL_C] = is_arith ? ar_c : 1'b0;
    nf[FL_N] = word_mode ? res[W-1] : res[HW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_out <= '0;
      wr_en_out  <= 1'b0;
      flags_out  <= '0;
    end else begin
      wr_en_out <= valid_in && writes;
      if (valid_in && writes) result_out <= res;
      if (valid_in && known)  flags_out  <= nf;
    end
  end

  // R11: reset clears the status vector
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (flags_out == '0) && !wr_en_out);

  // R8: compare never strobes a write
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_code == 4'd4) |=> !wr_en_out);

  // R7: bitwise group clears overflow and carry
  a_r7_logic_vc_clear: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_code >= 4'd5 && op_code <= 4'd8) |=> (!flags_out[FL_V] && !flags_out[FL_C]));

  // R10: idle cycles hold flags and result
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(flags_out) && $stable(result_out) && !wr_en_out));

  // R12: undefined opcodes touch nothing
  a_r12_undef_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_code > 4'd9) |=> ($stable(flags_out) && !wr_en_out));

  // R9: byte mode keeps the upper byte clear
  a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !word_mode && op_code <= 4'd9 && op_code != 4'd4) |=> (result_out[W-1:HW] == '0));

  // R6: negative flag follows the result's top bit
  a_r6_neg_msb: assert property (@(posedge clk) disable iff (rst)
    wr_en_out |-> (flags_out[FL_N] == ($past(word_mode) ? result_out[W-1] : result_out[HW-1])));

  // R4: a nonzero written result never carries zero
  a_r4_zero_consistent: assert property (@(posedge clk) disable iff (rst)
    (wr_en_out && result_out != '0) |-> !flags_out[FL_Z]);

endmodule

// File: tb/status_alu_test.sv
module status_alu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic        word_mode = 1'b1;
  logic [3:0]  op_code = '0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [4:0]  flags_in = '0;
  logic [15:0] result_out;
  logic        wr_en_out;
  logic [4:0]  flags_out;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string       tag;
    logic [15:0] res;
    logic        wr;
    logic [4:0]  flg;
  } exp_t;

  exp_t q[$];
  logic [15:0] exp_res = '0;
  logic [4:0]  exp_flg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_alu uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .word_mode(word_mode),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
    .result_out(result_out), .wr_en_out(wr_en_out), .flags_out(flags_out)
  );

  function automatic int sx(int v, int w);
    return (v >= (1 << (w-1))) ? v - (1 << w) : v;
  endfunction

  task automatic apply(string tag, bit v, bit wm, int op, int a, int b, bit [4:0] fin);
    int w, mask, mn, am, bm, r, t, cin;
    bit c, ov, e, z, n, ok, wr;
    @(negedge clk);
    valid_in = v; word_mode = wm; op_code = op[3:0];
    opnd_a = a[15:0]; opnd_b = b[15:0]; flags_in = fin;
    w = wm ? 16 : 8; mask = (1 << w) - 1; mn = 1 << (w-1);
    am = a & mask; bm = b & mask; r = 0; c = 0; ov = 0;
    cin = ((op == 1) || (op == 3)) ? int'(fin[1]) : 0;
    case (op)
      0, 1: begin
        r = (am + bm + cin) & mask; c = ((am + bm + cin) >> w) != 0;
        t = sx(am, w) + sx(bm, w) + cin; ov = (t >= mn) || (t < -mn);
      end
      2, 3, 4: begin
        r = (am - bm - cin) & mask; c = (am - bm - cin) < 0;
        t = sx(am, w) - sx(bm, w) - cin; ov = (t >= mn) || (t < -mn);
      end
      9: begin
        r = (0 - am) & mask; c = am != 0;
        t = -sx(am, w); ov = (t >= mn) || (t < -mn);
      end
      5: r = am & bm;
      6: r = am | bm;
      7: r = am ^ bm;
      8: r = ~am & mask;
      default: r = 0;
    endcase
    e  = (((op == 8) || (op == 9)) ? am : bm) == mn;
    z  = (r == 0) && (((op == 1) || (op == 3)) ? fin[3] : 1'b1);
    n  = ((r >> (w-1)) & 1) != 0;
    ok = (op >= 0) && (op <= 9);
    wr = v && ok && (op != 4);
    if (v && ok) exp_flg = {e, z, ov, c, n};
    if (wr) exp_res = r[15:0];
    q.push_back('{tag, exp_res, wr, exp_flg});
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        x = q.pop_front();
        checks++;
        if (result_out !== x.res || wr_en_out !== x.wr || flags_out !== x.flg) begin
          fails++;
          $display("FAIL %s: got res=%h wr=%b flg=%b, expected res=%h wr=%b flg=%b",
                   x.tag, result_out, wr_en_out, flags_out, x.res, x.wr, x.flg);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    checks++;
    if (flags_out !== 5'b0 || result_out !== 16'h0 || wr_en_out !== 1'b0) begin
      fails++;
      $display("FAIL R11: got res=%h wr=%b flg=%b, expected all zero", result_out, wr_en_out, flags_out);
    end
    @(negedge clk); rst = 1'b0;

    apply("R1 add",              1, 1, 0, 16'h1234, 16'h0001, 5'b00000);
    apply("R1 add carry wrap",   1, 1, 0, 16'hFFFF, 16'h0001, 5'b00000);
    apply("R1 addc carry in",    1, 1, 1, 16'h0005, 16'h0006, 5'b00010);
    apply("R3 add overflow",     1, 1, 0, 16'h7FFF, 16'h0001, 5'b00000);
    apply("R2 sub borrow",       1, 1, 2, 16'h0003, 16'h0005, 5'b00000);
    apply("R3 sub overflow",     1, 1, 2, 16'h8001, 16'h0002, 5'b00000);
    apply("R4 subc chained z",   1, 1, 3, 16'h0005, 16'h0004, 5'b01010);
    apply("R4 subc z broken",    1, 1, 3, 16'h0005, 16'h0004, 5'b00010);
    apply("R4 addc byte z",      1, 0, 1, 16'h00FF, 16'h0001, 5'b01000);
    apply("R5 marker word",      1, 1, 0, 16'h0001, 16'h8000, 5'b00000);
    apply("R5 marker byte",      1, 0, 0, 16'h0001, 16'h0080, 5'b00000);
    apply("R5 no marker word",   1, 1, 0, 16'h0001, 16'h0080, 5'b00000);
    apply("R5 neg minimum",      1, 1, 9, 16'h8000, 16'h0000, 5'b00000);
    apply("R2 neg",              1, 1, 9, 16'h0001, 16'h8000, 5'b00000);
    apply("R5 cpl byte marker",  1, 0, 8, 16'h0080, 16'h0000, 5'b00000);
    apply("R7 and",              1, 1, 5, 16'hF0F0, 16'h8F00, 5'b00110);
    apply("R7 or",               1, 1, 6, 16'h0F00, 16'h00F0, 5'b00110);
    apply("R7 xor zero",         1, 1, 7, 16'hA5A5, 16'hA5A5, 5'b00110);
    apply("R6 cpl word",         1, 1, 8, 16'h00FF, 16'h0000, 5'b00000);
    apply("R8 cmp equal",        1, 1, 4, 16'h4321, 16'h4321, 5'b00000);
    apply("R8 cmp less",         1, 0, 4, 16'h0010, 16'h0020, 5'b00000);
    apply("R9 byte add",         1, 0, 0, 16'h12F0, 16'h3420, 5'b00000);
    apply("R9 byte sub",         1, 0, 2, 16'hAB80, 16'hCD01, 5'b00000);
    apply("R10 idle",            0, 1, 0, 16'h1111, 16'h2222, 5'b00000);
    apply("R10 idle again",      0, 0, 9, 16'h0000, 16'h0000, 5'b11111);
    apply("R12 undefined op",    1, 1, 15, 16'h0000, 16'h0000, 5'b00000);
    apply("R12 undefined op 10", 1, 1, 10, 16'h0001, 16'h8000, 5'b00000);
    apply("R1 add after hold",   1, 1, 0, 16'h0000, 16'h0000, 5'b00000);
    for (int i = 0; i < 16; i++)
      apply("R3 sweep", 1, i[0], i % 10, (i * 16'h1357) & 16'hFFFF, (i * 16'h2468 + 16'h7F) & 16'hFFFF, i[4:0]);

    @(negedge clk); valid_in = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule